// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Target

This block models a serial memory target that a host drives over three wires: a select line, a serial clock and a data line. It also has a tri-stateable data return line, a width-select input and a store-permit input. It holds 16 Kbit of register storage by default. The storage is addressed either as 16-bit words or as bytes. Everything runs on one system clock. The select, serial clock and data-in wires pass through a synchronizer, and the block acts on edges of the synchronized serial clock. Each command is a start bit, a two-bit opcode and an address field. Writes carry a data field after the address.

A read streams words out for as long as select stays high, and the address wraps at the top of the array. A store (write, erase, fill-all, clear-all) is armed when the last command bit arrives and starts when select falls. The store then runs for a parameterised number of system clocks. While select is high, the data line reports busy or ready until the host shifts in a one.

The command decoder is a state machine with these states:
- S_IDLE: waits for a start bit.
- S_OPCODE: collects two opcode bits.
- S_ADDR: collects the address and decodes the command.
- S_DATA: collects write data.
- S_READ: streams read data.
- S_ARMED: a store is waiting for select to fall.
- S_DONE: an enable or disable command has completed.

Its transitions are:
- S_IDLE→S_OPCODE on a 1 while not busy.
- S_OPCODE→S_ADDR after two bits.
- S_ADDR→S_READ, S_DATA, S_ARMED or S_DONE on the last address bit, according to the opcode.
- S_DATA→S_ARMED on the last data bit.
- Every state→S_IDLE when select is low.

The store engine has three states:
- E_IDLE: no store is running.
- E_SWEEP: one word per clock is written for the all-location commands.
- E_HOLD: the timed wait.

Its transitions are E_IDLE→E_HOLD for a single-location store, E_IDLE→E_SWEEP→E_HOLD for an all-location store, and E_HOLD→E_IDLE when the count ends.

Top module: `microwire_eeprom`

## Requirements
- R1: Command bits are taken on rising serial-clock edges while select is high. Zeros before the first 1 are ignored. The 1 is followed by a two-bit opcode: 10 read, 01 write, 11 erase, 00 extended.
- R2: With org_wide_i=1 the address is ADDR_W bits and selects a 16-bit word. With org_wide_i=0 the address is ADDR_W+1 bits and selects a byte. In byte mode, even byte address 2k is the low byte (bits 7:0) of word k and 2k+1 is its high byte.
- R3: After the last address bit of a read, sdo_oe_o goes high and sdo_o shows one 0 bit. The addressed data then follows MSB first, one bit after each rising serial-clock edge.
- R4: While select stays high, a read continues with the next address and no extra 0 bit. Reading past the top address continues from address 0.
- R5: A write carries 16 (word) or 8 (byte) data bits MSB first after the address. The store replaces the old content and starts when select falls after the last data bit.
- R6: An erase sets the addressed location to all ones. Extended code 10 (the first two address bits) sets every location to all ones.
- R7: Extended code 01 followed by a data field writes that data to every location. In byte mode the byte is written to every byte.
- R8: Extended code 11 enables storing and 00 disables it. Storing is disabled after reset. A store command received while disabled changes no location and starts no busy period.
- R9: A store starts only if prog_en_i is high when select falls. The enable and disable commands take effect whatever prog_en_i is.
- R10: After a store starts, raising select makes sdo_oe_o=1 with sdo_o=0 for BUSY_CYCLES clocks, then sdo_o=1. A 1 shifted in on data-in returns sdo_oe_o to 0 after the next falling serial-clock edge.
- R11: Command bits received while a store is running are ignored and change no location.
- R12: Dropping select before a command is complete discards it. sdo_oe_o is 0 whenever select is low and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Select, active high |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial command and data in |
| org_wide_i | input | 1 | 1: 16-bit words, 0: bytes |
| prog_en_i | input | 1 | Store permit |
| sdo_o | output | 1 | Serial data / status out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 means high-Z) |

## Verification
The bench builds the block with ADDR_W=4, which gives 16 words or 32 bytes. This makes the read wrap from the top address to 0 and the full fill and clear sweeps short enough to reach. BUSY_CYCLES=600 makes the busy window longer than a complete write command, so a whole command can be shifted in during a store and shown to have no effect. The busy-to-ready change can also be timed against the parameter.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = WORD_W / 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPCODE,
        S_ADDR,
        S_DATA,
        S_READ,
        S_ARMED,
        S_DONE
    } cmd_state_e;

    typedef enum logic [1:0] {
        K_WORD,
        K_ERASE,
        K_FILL,
        K_CLEAR
    } store_kind_e;

    typedef enum logic [1:0] {
        E_IDLE,
        E_SWEEP,
        E_HOLD
    } eng_state_e;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain[0] <= '0;
        else         chain[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain[s] <= '0;
            else         chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/mw_array.sv
module mw_array
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int BUSY_CYCLES = 625000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              all_i,
    input  logic              erase_i,
    input  logic              byte_i,
    input  logic [ADDR_W:0]   addr_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              busy_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int HCW   = $clog2(BUSY_CYCLES + 1);
    localparam int LANES = WORD_W / BYTE_W;

    logic [WORD_W-1:0] mem [DEPTH];

    eng_state_e        eng_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [HCW-1:0]    hold_q;
    logic [WORD_W-1:0] fill_q;

    logic [WORD_W-1:0] new_val;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_lane;
    logic [WORD_W-1:0] wr_val;

    // value presented by the command: ones for erase, byte replicated in byte mode
    always_comb begin
        if (erase_i)     new_val = '1;
        else if (byte_i) new_val = {data_i[BYTE_W-1:0], data_i[BYTE_W-1:0]};
        else             new_val = data_i;
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_lane = '0;
        wr_val  = new_val;
        if (start_i && !all_i) begin
            wr_en   = 1'b1;
            wr_addr = byte_i ? addr_i[ADDR_W:1] : addr_i[ADDR_W-1:0];
            wr_lane = byte_i ? (addr_i[0] ? 2'b10 : 2'b01) : 2'b11;
        end else if (eng_q == E_SWEEP) begin
            wr_en   = 1'b1;
            wr_addr = ptr_q;
            wr_lane = '1;
            wr_val  = fill_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_lane[l]) mem[wr_addr][l*BYTE_W +: BYTE_W] <= wr_val[l*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q  <= E_IDLE;
            ptr_q  <= '0;
            hold_q <= '0;
            fill_q <= '0;
        end else begin
            unique case (eng_q)
                E_IDLE: begin
                    if (start_i) begin
                        fill_q <= new_val;
                        ptr_q  <= '0;
                        hold_q <= '0;
                        eng_q  <= all_i ? E_SWEEP : E_HOLD;
                    end
                end
                E_SWEEP: begin
                    ptr_q <= ptr_q + 1'b1;
                    if (ptr_q == '1) eng_q <= E_HOLD;
                end
                E_HOLD: begin
                    if (hold_q == HCW'(BUSY_CYCLES - 1)) eng_q <= E_IDLE;
                    else hold_q <= hold_q + 1'b1;
                end
                default: eng_q <= E_IDLE;
            endcase
        end
    end

    assign busy_o = (eng_q != E_IDLE);

    // R11: the decoder never launches a store while one is running
    a_r11_no_launch_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> !busy_o)
        else $error("a_r11_no_launch_while_busy");

    // R10: a launch always opens a busy period
    a_r10_busy_follows_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_o)
        else $error("a_r10_busy_follows_launch");

endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
    import mw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_i,
    input  logic              sk_i,
    input  logic              di_i,
    input  logic              org_wide_i,
    input  logic              prog_en_i,
    input  logic              busy_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              start_o,
    output logic              all_o,
    output logic              erase_o,
    output logic              byte_o,
    output logic [ADDR_W:0]   addr_o,
    output logic [WORD_W-1:0] data_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam int AF_W   = ADDR_W + 1;
    localparam int MAXLEN = (AF_W > WORD_W) ? AF_W : WORD_W;
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    cmd_state_e        state_q, state_d, decode_state;
    store_kind_e       kind_q, kind_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        op_q, ext_q, ext_now;
    logic [AF_W-1:0]   addr_q, addr_shift, addr_in;
    logic [WORD_W-1:0] data_q;
    logic [AF_W-1:0]   rd_ptr_q, ptr_inc, ptr_next;
    logic              sdo_q, wen_q, st_show_q, st_clr_q;
    logic              sk_q, cs_q, sk_rise, sk_fall, cs_fall;
    logic [CNT_W-1:0]  addr_len, data_len;
    logic              addr_last, data_last;
    logic [WORD_W-1:0] cur_word;
    logic [3:0]        bit_idx;

    assign sk_rise   = sk_i & ~sk_q;
    assign sk_fall   = ~sk_i & sk_q;
    assign cs_fall   = cs_q & ~cs_i;
    assign addr_len  = org_wide_i ? CNT_W'(ADDR_W) : CNT_W'(AF_W);
    assign data_len  = org_wide_i ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
    assign addr_last = (cnt_q == addr_len - 1'b1);
    assign data_last = (cnt_q == data_len - 1'b1);
    assign ext_now   = (cnt_q == CNT_W'(1)) ? {ext_q[1], di_i} : ext_q;

    assign addr_shift = {addr_q[AF_W-2:0], di_i};
    assign addr_in    = org_wide_i ? {1'b0, addr_shift[ADDR_W-1:0]} : addr_shift;

    assign ptr_inc   = rd_ptr_q + 1'b1;
    assign ptr_next  = org_wide_i ? {1'b0, ptr_inc[ADDR_W-1:0]} : ptr_inc;
    assign rd_addr_o = org_wide_i ? rd_ptr_q[ADDR_W-1:0] : rd_ptr_q[AF_W-1:1];
    assign cur_word  = org_wide_i ? rd_data_i
                     : {(rd_ptr_q[0] ? rd_data_i[WORD_W-1:BYTE_W] : rd_data_i[BYTE_W-1:0]),
                        {BYTE_W{1'b0}}};
    assign bit_idx   = 4'(WORD_W - 1) - cnt_q[3:0];

    // command decode at the last address bit
    always_comb begin
        decode_state = S_DONE;
        kind_d       = kind_q;
        unique case (op_q)
            2'b10: decode_state = S_READ;
            2'b01: begin decode_state = S_DATA;  kind_d = K_WORD;  end
            2'b11: begin decode_state = S_ARMED; kind_d = K_ERASE; end
            2'b00: begin
                unique case (ext_now)
                    2'b10:   begin decode_state = S_ARMED; kind_d = K_CLEAR; end
                    2'b01:   begin decode_state = S_DATA;  kind_d = K_FILL;  end
                    default: decode_state = S_DONE;
                endcase
            end
            default: decode_state = S_DONE;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!cs_i) begin
            state_d = S_IDLE;
        end else if (sk_rise) begin
            unique case (state_q)
                S_IDLE:   if (di_i && !busy_i) state_d = S_OPCODE;
                S_OPCODE: if (cnt_q == CNT_W'(1)) state_d = S_ADDR;
                S_ADDR:   if (addr_last) state_d = decode_state;
                S_DATA:   if (data_last) state_d = S_ARMED;
                S_READ, S_ARMED, S_DONE: state_d = state_q;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // command datapath
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sk_q     <= 1'b0;
            cs_q     <= 1'b0;
            cnt_q    <= '0;
            op_q     <= '0;
            ext_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            rd_ptr_q <= '0;
            sdo_q    <= 1'b0;
            wen_q    <= 1'b0;
            kind_q   <= K_WORD;
        end else begin
            sk_q <= sk_i;
            cs_q <= cs_i;
            if (!cs_i) begin
                cnt_q <= '0;
            end else if (sk_rise) begin
                unique case (state_q)
                    S_IDLE: begin
                        cnt_q  <= '0;
                        addr_q <= '0;
                        data_q <= '0;
                    end
                    S_OPCODE: begin
                        op_q  <= {op_q[0], di_i};
                        cnt_q <= (cnt_q == CNT_W'(1)) ? '0 : cnt_q + 1'b1;
                    end
                    S_ADDR: begin
                        addr_q <= addr_in;
                        if (cnt_q == '0)        ext_q[1] <= di_i;
                        if (cnt_q == CNT_W'(1)) ext_q[0] <= di_i;
                        if (addr_last) begin
                            cnt_q  <= '0;
                            kind_q <= kind_d;
                            if (op_q == 2'b10) begin
                                rd_ptr_q <= addr_in;
                                sdo_q    <= 1'b0;
                            end
                            if (op_q == 2'b00 && ext_now == 2'b11) wen_q <= 1'b1;
                            if (op_q == 2'b00 && ext_now == 2'b00) wen_q <= 1'b0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    S_DATA: begin
                        data_q <= {data_q[WORD_W-2:0], di_i};
                        cnt_q  <= data_last ? '0 : cnt_q + 1'b1;
                    end
                    S_READ: begin
                        sdo_q <= cur_word[bit_idx];
                        if (data_last) begin
                            cnt_q    <= '0;
                            rd_ptr_q <= ptr_next;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // store launch on the falling edge of select
    assign start_o = cs_fall && (state_q == S_ARMED) && wen_q && prog_en_i;
    assign all_o   = (kind_q == K_FILL) || (kind_q == K_CLEAR);
    assign erase_o = (kind_q == K_ERASE) || (kind_q == K_CLEAR);
    assign byte_o  = ~org_wide_i;
    assign addr_o  = addr_q;
    assign data_o  = data_q;

    // status display: set at launch, cleared on the falling edge after a shifted 1
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_show_q <= 1'b0;
            st_clr_q  <= 1'b0;
        end else if (start_o) begin
            st_show_q <= 1'b1;
            st_clr_q  <= 1'b0;
        end else if (!cs_i) begin
            st_clr_q <= 1'b0;
        end else if (st_clr_q && sk_fall) begin
            st_show_q <= 1'b0;
            st_clr_q  <= 1'b0;
        end else if (st_show_q && sk_rise && di_i) begin
            st_clr_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        sdo_oe_o = 1'b0;
        sdo_o    = 1'b0;
        if (cs_i) begin
            if (state_q == S_READ) begin
                sdo_oe_o = 1'b1;
                sdo_o    = sdo_q;
            end else if (st_show_q) begin
                sdo_oe_o = 1'b1;
                sdo_o    = ~busy_i;
            end
        end
    end

    // R12: a low select returns the decoder to idle
    a_r12_idle_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_i |=> state_q == S_IDLE)
        else $error("a_r12_idle_after_deselect");

    // R3: read data moves only after a rising serial-clock edge
    a_r3_read_bit_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_READ && $past(state_q == S_READ) && !$stable(sdo_q)) |-> $past(sk_rise))
        else $error("a_r3_read_bit_on_rise");

    // R9: a busy period only begins after an enabled, permitted launch
    a_r9_store_needs_permit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_i) |-> $past(prog_en_i && wen_q))
        else $error("a_r9_store_needs_permit");

    // R10: status display is dropped only on a falling serial-clock edge
    a_r10_status_off_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_show_q) |-> ($past(sk_fall) || $past(start_o)))
        else $error("a_r10_status_off_on_fall");

    // R2: address count stays inside the field width for the selected organisation
    a_r2_addr_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_ADDR) |-> (cnt_q < addr_len))
        else $error("a_r2_addr_count_bound");

endmodule

// File: rtl/microwire_eeprom.sv
module microwire_eeprom
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int BUSY_CYCLES = 625000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic org_wide_i,
    input  logic prog_en_i,
    output logic sdo_o,
    output logic sdo_oe_o
);

    logic [2:0]        pins_s;
    logic              start, all_sel, erase_sel, byte_sel, busy;
    logic [ADDR_W:0]   st_addr;
    logic [WORD_W-1:0] st_data, rd_data;
    logic [ADDR_W-1:0] rd_addr;

    mw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({cs_i, sclk_i, sdi_i}),
        .q_o    (pins_s)
    );

    mw_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cs_i       (pins_s[2]),
        .sk_i       (pins_s[1]),
        .di_i       (pins_s[0]),
        .org_wide_i (org_wide_i),
        .prog_en_i  (prog_en_i),
        .busy_i     (busy),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .start_o    (start),
        .all_o      (all_sel),
        .erase_o    (erase_sel),
        .byte_o     (byte_sel),
        .addr_o     (st_addr),
        .data_o     (st_data),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o)
    );

    mw_array #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_array (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .all_i     (all_sel),
        .erase_i   (erase_sel),
        .byte_i    (byte_sel),
        .addr_i    (st_addr),
        .data_i    (st_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .busy_o    (busy)
    );

endmodule

// File: tb/test_microwire_eeprom.sv
module test_microwire_eeprom;

    localparam int AW   = 4;
    localparam int BUSY = 600;
    localparam int H    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b1, pe = 1'b1;
    logic sdo, sdo_oe;
    int   n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    microwire_eeprom #(.ADDR_W(AW), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) i_microwire_eeprom (
        .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
        .org_wide_i(org), .prog_en_i(pe), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    // {word address, data}
    localparam logic [19:0] VEC [6] = '{
        {4'd0,  16'h0BAD}, {4'd3,  16'h3A5B}, {4'd7,  16'h7777},
        {4'd9,  16'h9C9C}, {4'd15, 16'hF00D}, {4'd1,  16'h1111}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int alen();
        return org ? AW : AW + 1;
    endfunction

    function automatic int dlen();
        return org ? 16 : 8;
    endfunction

    task automatic bit_out(input logic b);
        sdi = b; tick(H); sclk = 1'b1; tick(H); sclk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic sel();
        cs = 1'b1; tick(H);
    endtask

    task automatic desel();
        cs = 1'b0; sdi = 1'b0; tick(8);
    endtask

    task automatic ext_cmd(input logic [1:0] code);
        sel(); send(32'b100, 3); send(32'(code), 2); send(32'd0, alen() - 2); desel();
    endtask

    task automatic write_loc(input logic [31:0] a, input logic [31:0] d);
        sel(); send(32'b101, 3); send(a, alen()); send(d, dlen()); desel();
    endtask

    task automatic wait_ready();
        sel();
        for (int i = 0; i < 3000; i++) begin
            if (sdo_oe && sdo) break;
            tick(1);
        end
        bit_out(1'b1);
        desel();
    endtask

    task automatic read_start(input logic [31:0] a);
        sel(); send(32'b110, 3); send(a, alen());
    endtask

    task automatic rd_word(output logic [15:0] w);
        w = '0;
        for (int i = 0; i < dlen(); i++) begin
            bit_out(1'b0);
            w = {w[14:0], sdo};
        end
    endtask

    task automatic read_loc(input logic [31:0] a, output logic [15:0] w);
        read_start(a); rd_word(w); desel();
    endtask

    initial begin
        logic [15:0] w;
        int t;
        tick(5);
        check("R12 reset oe", 32'(sdo_oe), 32'd0);
        rst_n = 1'b1; tick(4);

        // R8: disabled after reset, no busy period started
        write_loc(2, 16'h1111);
        tick(20); sel();
        check("R8 no launch when disabled", 32'(sdo_oe), 32'd0);
        desel();
        ext_cmd(2'b11);
        write_loc(2, 16'hAAAA); wait_ready();
        // R3: dummy zero then data
        read_start(2);
        check("R3 oe after address", 32'(sdo_oe), 32'd1);
        check("R3 dummy bit", 32'(sdo), 32'd0);
        rd_word(w); desel();
        check("R3 read data", 32'(w), 32'hAAAA);

        // R5: table of writes and readbacks
        foreach (VEC[k]) begin
            write_loc(32'(VEC[k][19:16]), 32'(VEC[k][15:0]));
            wait_ready();
            read_loc(32'(VEC[k][19:16]), w);
            check("R5 write/readback", 32'(w), 32'(VEC[k][15:0]));
        end

        // R5: overwrite without erase
        write_loc(9, 16'h0660); wait_ready();
        read_loc(9, w);
        check("R5 overwrite", 32'(w), 32'h0660);

        // R1: leading zeros before start bit
        sel(); send(32'b00, 2); send(32'b110, 3); send(32'd15, alen()); rd_word(w); desel();
        check("R1 leading zeros", 32'(w), 32'hF00D);

        // R4: sequential read with wrap and no dummy
        read_start(15); rd_word(w);
        check("R4 first word", 32'(w), 32'hF00D);
        rd_word(w);
        check("R4 wrap to 0", 32'(w), 32'h0BAD);
        rd_word(w); desel();
        check("R4 next word", 32'(w), 32'h1111);

        // R10: busy then ready status, dummy 1 returns high-Z
        write_loc(5, 16'h0F0F);
        sel();
        check("R10 status oe", 32'(sdo_oe), 32'd1);
        check("R10 busy shows 0", 32'(sdo), 32'd0);
        t = 0;
        while (!sdo && t < 3000) begin tick(1); t++; end
        check("R10 ready shows 1", 32'(sdo), 32'd1);
        check("R10 busy length", 32'(t > BUSY - 40 && t < BUSY + 10), 32'd1);
        bit_out(1'b1); tick(4);
        check("R10 high-Z after dummy 1", 32'(sdo_oe), 32'd0);
        desel();

        // R11: a full command during busy is ignored
        write_loc(6, 16'h5555);
        write_loc(6, 16'hDEAD);
        tick(BUSY + 100);
        read_loc(6, w);
        check("R11 ignored while busy", 32'(w), 32'h5555);

        // R6: single erase
        sel(); send(32'b111, 3); send(32'd6, alen()); desel(); wait_ready();
        read_loc(6, w);
        check("R6 erase to ones", 32'(w), 32'hFFFF);

        // R12: aborted write and aborted read
        sel(); send(32'b101, 3); send(32'd7, alen()); send(32'hAB, 8); desel();
        read_loc(7, w);
        check("R12 aborted write", 32'(w), 32'h7777);
        read_start(7); desel();
        check("R12 oe low when deselected", 32'(sdo_oe), 32'd0);

        // R2: byte organisation
        org = 1'b0;
        write_loc(7, 8'hC3); wait_ready();
        org = 1'b1;
        read_loc(3, w);
        check("R2 byte 7 is high byte of word 3", 32'(w), 32'hC35B);
        org = 1'b0;
        read_start(6); rd_word(w);
        check("R2 byte 6 low byte", 32'(w), 32'h005B);
        rd_word(w); desel();
        check("R2 byte 7 follows", 32'(w), 32'h00C3);
        org = 1'b1;

        // R8: disable blocks storing
        ext_cmd(2'b00);
        write_loc(3, 16'h0000); tick(20);
        read_loc(3, w);
        check("R8 disabled write ignored", 32'(w), 32'hC35B);

        // R9: enable works with prog_en low, store blocked while low
        pe = 1'b0;
        ext_cmd(2'b11);
        write_loc(3, 16'h0000); tick(20);
        read_loc(3, w);
        check("R9 prog_en low blocks", 32'(w), 32'hC35B);
        pe = 1'b1;
        write_loc(3, 16'h1357); wait_ready();
        read_loc(3, w);
        check("R9 enable ignored prog_en", 32'(w), 32'h1357);

        // R7: fill all
        sel(); send(32'b100, 3); send(32'b01, 2); send(32'd0, alen() - 2); send(32'h5A3C, 16); desel();
        wait_ready();
        read_start(15); rd_word(w);
        check("R7 fill top", 32'(w), 32'h5A3C);
        rd_word(w); desel();
        check("R7 fill bottom", 32'(w), 32'h5A3C);

        // R6: clear all
        ext_cmd(2'b10); wait_ready();
        read_loc(9, w);
        check("R6 clear all", 32'(w), 32'hFFFF);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule